// File: doc/BRIEF.md
# 64-bit Initiator Lane Steering

This block is the initiator-side lane controller for a parallel bus whose data path is either 32 or 64 bits wide. When a transaction is launched, it decides from the command kind, start address, dword count and link context whether to ask the target for a wide transfer. It then sequences the address phase and the data phases. In each data phase it decides what goes on the lower and upper data lanes and their active-low byte enables.

Write data comes from a local source that presents one quadword at a time, split into a lower and an upper dword with their byte enables. The block pulses `src_pop` when it has used a quadword. The target may decline a wide request by asserting `devsel` without `ack64`. In that case the upper dword of each quadword is sent on the lower lanes in the following phase. A dword counter moves by two per wide phase and by one per narrow phase, and it marks the final phase.

Top module: `lane_steer_top`

## Requirements
- R1: `req64` is high only while `frame` is high. Both rise together in the address phase. If a wide request is made, `req64` falls in the same cycle as `frame`.
- R2: `kind` encodings are 0 I/O read, 1 I/O write, 2 config read, 3 config write, 4 special, 5 non-prefetchable memory read, 6 prefetchable memory read, 7 memory write. A wide request is made only for kinds 6 and 7.
- R3: No wide request is made when `addr[2:0]` is non-zero. No wide request is made when the address lies in the last quadword of a cache line, that is when every address bit from 3 up to log2(`LINE_BYTES`)-1 is one. `LINE_BYTES` defaults to 32.
- R4: No wide request is made for a read of one dword or for a memory write of one or two dwords. A two-dword prefetchable read may go wide.
- R5: When `upstream` is high and `prim_wide_cap` is low, no wide request is made.
- R6: When `resume_wr` is high, `prev_ack64` is low and `prev_retry` is low, no wide request is made. A previous retry, or an earlier `ack64`, lifts this rule.
- R7: If `ack64` is seen together with `devsel`, each data phase moves two dwords on both lane pairs. The transaction takes ceil(count/2) data phases, and `frame` is low during the last one. A narrow transaction takes one data phase per dword.
- R8: If a wide write meets `devsel` without `ack64`, the phase carries the source's lower dword on `ad_lo`. The next phase carries the upper dword and its byte enables on `ad_lo`/`be_lo_n`, and `src_pop` fires in that phase.
- R9: A wide write with an odd dword count drives `be_hi_n` to 4'hF in its final phase.
- R10: For a wide read, both byte-enable nibbles are 4'h0. For a narrow read, `be_lo_n` is 4'h0 and `be_hi_n` is 4'hF. Reads never pulse `src_pop`.
- R11: A narrow write that starts with `addr[2]` set takes its first dword from the source's upper half. It pops after that phase and then goes on lower, upper.
- R12: After reset, `busy`, `frame`, `req64` and `src_pop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a transaction (taken when not busy) |
| kind | input | 3 | Command kind, encoding in R2 |
| addr | input | DW | Start byte address |
| dword_cnt | input | CNT_W | Number of dwords, at least 1 |
| upstream | input | 1 | Transaction heads toward the primary side |
| resume_wr | input | 1 | This launch resumes a disconnected memory write |
| prev_ack64 | input | 1 | The interrupted attempt saw `ack64` |
| prev_retry | input | 1 | The interrupted attempt ended with a retry |
| prim_wide_cap | input | 1 | Wide path on the primary side was detected at reset |
| devsel | input | 1 | Target claimed the transaction |
| ack64 | input | 1 | Target accepts wide transfers |
| data_ack | input | 1 | Current data phase completes this cycle |
| src_lo_data | input | DW | Lower dword of current source quadword |
| src_lo_be_n | input | DW/8 | Byte enables of lower dword, active low |
| src_hi_data | input | DW | Upper dword of current source quadword |
| src_hi_be_n | input | DW/8 | Byte enables of upper dword, active low |
| busy | output | 1 | A transaction is in progress |
| frame | output | 1 | Frame (active high) |
| req64 | output | 1 | Wide transfer request (active high) |
| ad_lo | output | DW | Lower lanes |
| ad_hi | output | DW | Upper lanes |
| be_lo_n | output | DW/8 | Lower byte enables |
| be_hi_n | output | DW/8 | Upper byte enables |
| src_pop | output | 1 | Current source quadword consumed |

## Verification
The assertions check on every cycle that `req64` never appears without `frame`. They check that the kind, upstream-capability and resume rules suppress the wide request in the address phase after launch. They also check that read data phases keep the lower byte enables low. Lane contents can only be shown by the bench's scenarios: the redirected upper dword in the phase after a decline, the forced-off upper enables at an odd end, the upper-half start of an unaligned narrow write, and the number of data phases per count.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  typedef enum logic [2:0] {
    K_IO_RD     = 3'd0,
    K_IO_WR     = 3'd1,
    K_CFG_RD    = 3'd2,
    K_CFG_WR    = 3'd3,
    K_SPECIAL   = 3'd4,
    K_MEM_RD    = 3'd5,
    K_MEM_RD_PF = 3'd6,
    K_MEM_WR    = 3'd7
  } txn_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } phase_st_e;
endpackage

// File: rtl/lane_rst_sync.sv
module lane_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lane_req64_decide.sv
module lane_req64_decide
  import lane_steer_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int LINE_LOG2 = 5
) (
  input  logic [2:0]           kind,
  input  logic [LINE_LOG2-1:0] addr_lo,
  input  logic [CNT_W-1:0]     dword_cnt,
  input  logic                 upstream,
  input  logic                 prim_wide_cap,
  input  logic                 resume_wr,
  input  logic                 prev_ack64,
  input  logic                 prev_retry,
  output logic                 want_wide,
  output logic                 is_write
);
  localparam logic [CNT_W-1:0] ONE_DW = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_DW = CNT_W'(2);

  txn_kind_e k;
  logic kind_ok, aligned, near_top, too_short, cap_block, resume_block;

  always_comb begin
    k            = txn_kind_e'(kind);
    is_write     = (k == K_IO_WR) || (k == K_CFG_WR) ||
                   (k == K_SPECIAL) || (k == K_MEM_WR);
    kind_ok      = (k == K_MEM_RD_PF) || (k == K_MEM_WR);
    aligned      = (addr_lo[2:0] == 3'b000);
    near_top     = &addr_lo[LINE_LOG2-1:3];
    too_short    = (k == K_MEM_WR) ? (dword_cnt <= TWO_DW)
                                   : (dword_cnt == ONE_DW);
    cap_block    = upstream && !prim_wide_cap;
    resume_block = resume_wr && !prev_ack64 && !prev_retry;
    want_wide    = kind_ok && aligned && !near_top && !too_short &&
                   !cap_block && !resume_block;
  end
endmodule

// File: rtl/lane_phase_ctrl.sv
module lane_phase_ctrl
  import lane_steer_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             want_wide,
  input  logic             is_write,
  input  logic [DW-1:0]    addr,
  input  logic [CNT_W-1:0] dword_cnt,
  input  logic             devsel,
  input  logic             ack64,
  input  logic             data_ack,
  output phase_st_e        st_q,
  output logic             req64_q,
  output logic             eff_wide,
  output logic             half_q,
  output logic             last_ph,
  output logic             odd_tail,
  output logic             is_wr_q,
  output logic             src_pop,
  output logic             data_phase,
  output logic [DW-1:0]    addr_q
);
  localparam logic [CNT_W-1:0] ONE_DW = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_DW = CNT_W'(2);

  phase_st_e        st_n;
  logic             req64_n, half_n, is_wr_n, seen_q, seen_n, wide_q, wide_n;
  logic [CNT_W-1:0] rem_q, rem_n, step;
  logic [DW-1:0]    addr_n;
  logic             accept, clk_en;

  // live lane width: before the claim the wide request is assumed honoured
  always_comb begin
    if (!req64_q)     eff_wide = 1'b0;
    else if (seen_q)  eff_wide = wide_q;
    else if (devsel)  eff_wide = ack64;
    else              eff_wide = 1'b1;
  end

  always_comb begin
    data_phase = (st_q == ST_DATA);
    step       = (eff_wide && rem_q >= TWO_DW) ? TWO_DW : ONE_DW;
    last_ph    = (rem_q <= step);
    odd_tail   = eff_wide && (rem_q == ONE_DW);
    src_pop    = data_phase && data_ack && is_wr_q &&
                 (eff_wide || half_q || last_ph);
    accept     = (st_q == ST_IDLE) && start;
    clk_en     = accept || (st_q != ST_IDLE);
  end

  always_comb begin
    st_n    = st_q;
    req64_n = req64_q;
    half_n  = half_q;
    is_wr_n = is_wr_q;
    seen_n  = seen_q;
    wide_n  = wide_q;
    rem_n   = rem_q;
    addr_n  = addr_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n    = ST_ADDR;
          req64_n = want_wide;
          half_n  = want_wide ? 1'b0 : addr[2];
          is_wr_n = is_write;
          seen_n  = 1'b0;
          wide_n  = 1'b0;
          rem_n   = dword_cnt;
          addr_n  = addr;
        end
      end
      ST_ADDR: st_n = ST_DATA;
      ST_DATA: begin
        if (devsel && !seen_q) begin
          seen_n = 1'b1;
          wide_n = req64_q && ack64;
        end
        if (data_ack) begin
          rem_n  = rem_q - step;
          half_n = eff_wide ? 1'b0 : ~half_q;
          if (last_ph) begin
            st_n    = ST_IDLE;
            req64_n = 1'b0;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      req64_q <= 1'b0;
      half_q  <= 1'b0;
      is_wr_q <= 1'b0;
      seen_q  <= 1'b0;
      wide_q  <= 1'b0;
      rem_q   <= '0;
      addr_q  <= '0;
    end else if (clk_en) begin
      st_q    <= st_n;
      req64_q <= req64_n;
      half_q  <= half_n;
      is_wr_q <= is_wr_n;
      seen_q  <= seen_n;
      wide_q  <= wide_n;
      rem_q   <= rem_n;
      addr_q  <= addr_n;
    end
  end
endmodule

// File: rtl/lane_mux.sv
module lane_mux
  import lane_steer_pkg::*;
#(
  parameter int DW = 32
) (
  input  phase_st_e        st,
  input  logic             is_wr,
  input  logic             eff_wide,
  input  logic             half,
  input  logic             odd_tail,
  input  logic [DW-1:0]    addr_q,
  input  logic [DW-1:0]    src_lo_data,
  input  logic [DW/8-1:0]  src_lo_be_n,
  input  logic [DW-1:0]    src_hi_data,
  input  logic [DW/8-1:0]  src_hi_be_n,
  output logic [DW-1:0]    ad_lo,
  output logic [DW-1:0]    ad_hi,
  output logic [DW/8-1:0]  be_lo_n,
  output logic [DW/8-1:0]  be_hi_n
);
  localparam int BW = DW/8;
  localparam logic [BW-1:0] BE_OFF = {BW{1'b1}};
  localparam logic [BW-1:0] BE_ALL = {BW{1'b0}};

  always_comb begin
    ad_lo   = '0;
    ad_hi   = '0;
    be_lo_n = BE_OFF;
    be_hi_n = BE_OFF;
    unique case (st)
      ST_ADDR: ad_lo = addr_q;
      ST_DATA: begin
        if (!is_wr) begin
          be_lo_n = BE_ALL;
          be_hi_n = eff_wide ? BE_ALL : BE_OFF;
        end else if (eff_wide) begin
          ad_lo   = src_lo_data;
          ad_hi   = src_hi_data;
          be_lo_n = src_lo_be_n;
          be_hi_n = odd_tail ? BE_OFF : src_hi_be_n;
        end else begin
          ad_lo   = half ? src_hi_data : src_lo_data;
          be_lo_n = half ? src_hi_be_n : src_lo_be_n;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lane_steer_top.sv
module lane_steer_top
  import lane_steer_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CNT_W      = 10,
  parameter int LINE_BYTES = 32,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       kind,
  input  logic [DW-1:0]    addr,
  input  logic [CNT_W-1:0] dword_cnt,
  input  logic             upstream,
  input  logic             resume_wr,
  input  logic             prev_ack64,
  input  logic             prev_retry,
  input  logic             prim_wide_cap,
  input  logic             devsel,
  input  logic             ack64,
  input  logic             data_ack,
  input  logic [DW-1:0]    src_lo_data,
  input  logic [DW/8-1:0]  src_lo_be_n,
  input  logic [DW-1:0]    src_hi_data,
  input  logic [DW/8-1:0]  src_hi_be_n,
  output logic             busy,
  output logic             frame,
  output logic             req64,
  output logic [DW-1:0]    ad_lo,
  output logic [DW-1:0]    ad_hi,
  output logic [DW/8-1:0]  be_lo_n,
  output logic [DW/8-1:0]  be_hi_n,
  output logic             src_pop
);
  localparam int LINE_LOG2 = $clog2(LINE_BYTES);

  logic          rst_n_sync;
  logic          want_wide, is_write;
  phase_st_e     st;
  logic          req64_q, eff_wide, half_q, last_ph, odd_tail, is_wr_q;
  logic          data_phase;
  logic [DW-1:0] addr_q;

  lane_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  lane_req64_decide #(.CNT_W(CNT_W), .LINE_LOG2(LINE_LOG2)) u_decide (
    .kind(kind), .addr_lo(addr[LINE_LOG2-1:0]), .dword_cnt(dword_cnt),
    .upstream(upstream), .prim_wide_cap(prim_wide_cap),
    .resume_wr(resume_wr), .prev_ack64(prev_ack64), .prev_retry(prev_retry),
    .want_wide(want_wide), .is_write(is_write)
  );

  lane_phase_ctrl #(.DW(DW), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_sync), .start(start), .want_wide(want_wide),
    .is_write(is_write), .addr(addr), .dword_cnt(dword_cnt),
    .devsel(devsel), .ack64(ack64), .data_ack(data_ack),
    .st_q(st), .req64_q(req64_q), .eff_wide(eff_wide), .half_q(half_q),
    .last_ph(last_ph), .odd_tail(odd_tail), .is_wr_q(is_wr_q),
    .src_pop(src_pop), .data_phase(data_phase), .addr_q(addr_q)
  );

  lane_mux #(.DW(DW)) u_mux (
    .st(st), .is_wr(is_wr_q), .eff_wide(eff_wide), .half(half_q),
    .odd_tail(odd_tail), .addr_q(addr_q),
    .src_lo_data(src_lo_data), .src_lo_be_n(src_lo_be_n),
    .src_hi_data(src_hi_data), .src_hi_be_n(src_hi_be_n),
    .ad_lo(ad_lo), .ad_hi(ad_hi), .be_lo_n(be_lo_n), .be_hi_n(be_hi_n)
  );

  always_comb begin
    busy  = (st != ST_IDLE);
    frame = (st == ST_ADDR) || (data_phase && !last_ph);
    req64 = req64_q && frame;
  end
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [2:0]    kind,
  input logic          upstream,
  input logic          prim_wide_cap,
  input logic          resume_wr,
  input logic          prev_ack64,
  input logic          prev_retry,
  input logic          frame,
  input logic          req64,
  input logic          data_phase,
  input logic [BW-1:0] be_lo_n
);
  logic rd_txn_q;
  logic launch;

  assign launch = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_txn_q <= 1'b0;
    else if (launch) rd_txn_q <= (kind == 3'd0) || (kind == 3'd2) ||
                                 (kind == 3'd5) || (kind == 3'd6);
  end

  a_r1_req64_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    req64 |-> frame);

  a_r2_kind_blocks_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && (kind != 3'd6) && (kind != 3'd7)) |=> !req64);

  a_r5_upstream_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && upstream && !prim_wide_cap) |=> !req64);

  a_r6_resume_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && resume_wr && !prev_ack64 && !prev_retry) |=> !req64);

  a_r10_read_be_low: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && rd_txn_q) |-> (be_lo_n == '0));
endmodule

bind lane_steer_top lane_steer_chk #(.BW(DW/8)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .start(start), .busy(busy), .kind(kind),
  .upstream(upstream), .prim_wide_cap(prim_wide_cap), .resume_wr(resume_wr),
  .prev_ack64(prev_ack64), .prev_retry(prev_retry), .frame(frame),
  .req64(req64), .data_phase(data_phase), .be_lo_n(be_lo_n)
);

// File: tb/lane_steer_tb.sv
module lane_steer_top_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] addr;
    logic [9:0]  cnt;
    logic        up;
    logic        cap;
    logic        res;
    logic        pack;
    logic        pretry;
    logic        exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd7, 32'h00, 10'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 mem write wide
    '{3'd6, 32'h40, 10'd8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 prefetch read wide
    '{3'd1, 32'h00, 10'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 io write
    '{3'd2, 32'h00, 10'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 cfg read
    '{3'd4, 32'h00, 10'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 special
    '{3'd5, 32'h00, 10'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 nonprefetch read
    '{3'd7, 32'h04, 10'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 misaligned
    '{3'd7, 32'h18, 10'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 line top
    '{3'd6, 32'h00, 10'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 single read
    '{3'd7, 32'h00, 10'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 two-dword write
    '{3'd6, 32'h00, 10'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 two-dword read
    '{3'd7, 32'h00, 10'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 no cap
    '{3'd7, 32'h00, 10'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 cap
    '{3'd7, 32'h00, 10'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 resume narrow
    '{3'd7, 32'h00, 10'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R6 after retry
    '{3'd7, 32'h00, 10'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}  // R6 ack seen
  };

  logic        clk, rst_n, start, upstream, resume_wr, prev_ack64, prev_retry;
  logic        prim_wide_cap, devsel, ack64, data_ack;
  logic [2:0]  kind;
  logic [31:0] addr;
  logic [9:0]  dword_cnt;
  logic [31:0] src_lo_data, src_hi_data;
  logic [3:0]  src_lo_be_n, src_hi_be_n;
  logic        busy, frame, req64, src_pop;
  logic [31:0] ad_lo, ad_hi;
  logic [3:0]  be_lo_n, be_hi_n;

  logic [7:0]  q;
  logic        q_clr;
  int          nchk, nerr;
  bit          finished;

  lane_steer_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .addr(addr),
    .dword_cnt(dword_cnt), .upstream(upstream), .resume_wr(resume_wr),
    .prev_ack64(prev_ack64), .prev_retry(prev_retry),
    .prim_wide_cap(prim_wide_cap), .devsel(devsel), .ack64(ack64),
    .data_ack(data_ack), .src_lo_data(src_lo_data), .src_lo_be_n(src_lo_be_n),
    .src_hi_data(src_hi_data), .src_hi_be_n(src_hi_be_n), .busy(busy),
    .frame(frame), .req64(req64), .ad_lo(ad_lo), .ad_hi(ad_hi),
    .be_lo_n(be_lo_n), .be_hi_n(be_hi_n), .src_pop(src_pop)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // quadword source model
  always @(posedge clk) begin
    if (q_clr)        q <= 8'd0;
    else if (src_pop) q <= q + 8'd1;
  end
  assign src_lo_data = 32'hA000_0000 + {23'd0, q, 1'b0};
  assign src_hi_data = 32'hA000_0000 + {23'd0, q, 1'b1};
  assign src_lo_be_n = q[3:0] ^ 4'hA;
  assign src_hi_be_n = q[3:0] ^ 4'h5;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  // returns in the address phase, 1 time unit after the edge
  task automatic launch(input logic [2:0] k, input logic [31:0] a, input logic [9:0] c,
                        input logic up, input logic cp, input logic rs,
                        input logic pa, input logic pr);
    @(posedge clk); #1;
    kind = k; addr = a; dword_cnt = c; upstream = up; prim_wide_cap = cp;
    resume_wr = rs; prev_ack64 = pa; prev_retry = pr; start = 1'b1; q_clr = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; q_clr = 1'b0;
  endtask

  task automatic to_data();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic ds, input logic ak);
    devsel = ds; ack64 = ak; data_ack = 1'b1;
    #2;
  endtask

  task automatic advance();
    @(posedge clk); #1;
    data_ack = 1'b0; devsel = 1'b0; ack64 = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    nchk = 0; nerr = 0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0; kind = '0; addr = '0; dword_cnt = 10'd1;
    upstream = 1'b0; resume_wr = 1'b0; prev_ack64 = 1'b0; prev_retry = 1'b0;
    prim_wide_cap = 1'b1; devsel = 1'b0; ack64 = 1'b0; data_ack = 1'b0; q_clr = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R12 busy in reset", busy, 0);
    chk("R12 frame in reset", frame, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk("R12 busy after reset", busy, 0);
    chk("R12 req64 after reset", req64, 0);
    chk("R12 src_pop after reset", src_pop, 0);

    // table of request decisions and phase counts
    for (int i = 0; i < NV; i++) begin
      int n;
      int exp_ph;
      launch(VECS[i].kind, VECS[i].addr, VECS[i].cnt, VECS[i].up, VECS[i].cap,
             VECS[i].res, VECS[i].pack, VECS[i].pretry);
      chk($sformatf("R1 frame in address phase vec%0d", i), frame, 1);
      chk($sformatf("R2/R3/R4/R5/R6 req64 vec%0d", i), req64, VECS[i].exp);
      exp_ph = VECS[i].exp ? (int'(VECS[i].cnt) + 1) / 2 : int'(VECS[i].cnt);
      to_data();
      n = 0;
      while (busy && n < 64) begin
        drive(1'b1, 1'b1);
        advance();
        n++;
      end
      chk($sformatf("R7 data phase count vec%0d", i), n, exp_ph);
    end

    // R7 accepted wide write, 4 dwords
    launch(3'd7, 32'h0, 10'd4, 0, 1, 0, 0, 0);
    chk("R1 req64 with frame", {req64, frame}, 2'b11);
    to_data();
    drive(1'b1, 1'b1);
    chk("R7 wide ph1 lanes", {ad_hi, ad_lo}, {32'hA000_0001, 32'hA000_0000});
    chk("R7 wide ph1 be", {be_hi_n, be_lo_n, frame}, {4'h5, 4'hA, 1'b1});
    advance();
    drive(1'b1, 1'b1);
    chk("R7 wide ph2 lanes", {ad_hi, ad_lo}, {32'hA000_0003, 32'hA000_0002});
    chk("R7 wide last frame low", frame, 0);
    chk("R1 req64 falls with frame", req64, 0);
    advance();
    chk("R7 idle after", busy, 0);

    // R8 declined wide write, 4 dwords
    launch(3'd7, 32'h0, 10'd4, 0, 1, 0, 0, 0);
    to_data();
    drive(1'b1, 1'b0);
    chk("R8 decline ph1", {ad_lo, be_lo_n, src_pop}, {32'hA000_0000, 4'hA, 1'b0});
    advance();
    drive(1'b0, 1'b0);
    chk("R8 redirect ph2", {ad_lo, be_lo_n, src_pop}, {32'hA000_0001, 4'h5, 1'b1});
    advance();
    drive(1'b0, 1'b0);
    chk("R8 ph3", {ad_lo, be_lo_n}, {32'hA000_0002, 4'hB});
    advance();
    drive(1'b0, 1'b0);
    chk("R8 redirect ph4 last", {ad_lo, be_lo_n, frame}, {32'hA000_0003, 4'h4, 1'b0});
    advance();

    // R9 odd-ending wide write, 3 dwords
    launch(3'd7, 32'h0, 10'd3, 0, 1, 0, 0, 0);
    chk("R9 wide requested", req64, 1);
    to_data();
    drive(1'b1, 1'b1);
    chk("R9 ph1 upper be", be_hi_n, 4'h5);
    advance();
    drive(1'b1, 1'b1);
    chk("R9 last upper be off", {ad_lo, be_lo_n, be_hi_n, frame},
        {32'hA000_0002, 4'hB, 4'hF, 1'b0});
    advance();

    // R10 wide and narrow reads
    launch(3'd6, 32'h0, 10'd4, 0, 1, 0, 0, 0);
    to_data();
    drive(1'b1, 1'b1);
    chk("R10 wide read be", {be_hi_n, be_lo_n, src_pop}, {4'h0, 4'h0, 1'b0});
    advance();
    drive(1'b1, 1'b1);
    chk("R10 wide read last", {be_hi_n, be_lo_n, src_pop, frame}, {4'h0, 4'h0, 1'b0, 1'b0});
    advance();
    launch(3'd5, 32'h0, 10'd2, 0, 1, 0, 0, 0);
    to_data();
    drive(1'b1, 1'b0);
    chk("R10 narrow read be", {be_hi_n, be_lo_n, src_pop}, {4'hF, 4'h0, 1'b0});
    advance();
    drive(1'b1, 1'b0);
    advance();

    // R11 narrow write from upper half
    launch(3'd7, 32'h4, 10'd3, 0, 1, 0, 0, 0);
    chk("R11 narrow request", req64, 0);
    to_data();
    drive(1'b1, 1'b0);
    chk("R11 ph1 upper half", {ad_lo, be_lo_n, src_pop}, {32'hA000_0001, 4'h5, 1'b1});
    advance();
    drive(1'b1, 1'b0);
    chk("R11 ph2 lower half", {ad_lo, be_lo_n, src_pop}, {32'hA000_0002, 4'hB, 1'b0});
    advance();
    drive(1'b1, 1'b0);
    chk("R11 ph3 last", {ad_lo, be_lo_n, src_pop, frame}, {32'hA000_0003, 4'h4, 1'b1, 1'b0});
    advance();
    chk("R11 idle after", busy, 0);

    finish_run();
  end
endmodule